// File: doc/BRIEF.md
# DMA Sample Byte Sequencer

This block breaks audio sample frames into single-byte transfers over an 8-bit DMA-style handshake, and builds frames back up from such transfers. The capture side and the playback side each have their own request and acknowledge pair. For every byte the block raises a request and waits for the host to acknowledge it. The host then moves one byte under a read strobe (capture) or a write strobe (playback). When every byte of a frame has moved, the block gives a one-cycle completion pulse.

The active format decides how many bytes a frame has and in what order they move. A 2-bit format select picks mono or stereo, and 8-bit or 16-bit samples. Each side samples the format at the start of a frame and keeps it until that frame is complete. A change of the select in the middle of a frame therefore shows up only in the next frame.

A frame is held as a 32-bit word made of byte lanes; lane k is bits 8k+7:8k. Capture frames come in from the sample datapath through a valid/take pair. Playback frames are put together in an output register that is complete on the cycle the done pulse is high.

Top module: `dmaByteSeq`

## Requirements
- R1: fmtSel encodes 00 = 8-bit mono (1 byte per frame), 01 = 16-bit mono (2 bytes), 10 = 8-bit stereo (2 bytes), 11 = 16-bit stereo (4 bytes).
- R2: On capture, bytes leave on busDataOut in this order. 8-bit mono: bits 7:0. 16-bit mono: 7:0 then 15:8. 8-bit stereo: left (15:8) then right (7:0). 16-bit stereo: left low 23:16, left high 31:24, right low 7:0, right high 15:8. The byte is valid while capAck and rdStrobe are high.
- R3: On playback, written bytes land in playFrame in the same positions as in R2. Bits the format does not use read as zero.
- R4: A byte moves on a cycle where the request, the acknowledge and the strobe are all high. The request is low on the next cycle. It rises again only after the acknowledge has gone low.
- R5: capTake is high for one cycle, and capFrame is loaded, when capValid is high and no capture frame is held. capReq is high only while a frame is held.
- R6: playReq rises at a frame start only while playSpace is high. Inside a frame it rises regardless of playSpace.
- R7: capDone or playDone is high for exactly the one cycle after the last byte of a frame moves. The next frame starts again from its first byte.
- R8: A change of fmtSel after a frame has started (capture: after the load; playback: after the first byte) does not change that frame's byte count or order.
- R9: During reset, capReq, playReq, capDone, playDone and capTake are low.
- R10: A strobe without an acknowledge, or an acknowledge without a strobe, moves no byte. The request stays high and the same byte is presented or awaited.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fmtSel | input | 2 | Format select (R1 encoding) |
| capValid | input | 1 | Capture frame available |
| capFrame | input | 32 | Capture frame lanes |
| capTake | output | 1 | Capture frame accepted this cycle |
| capReq | output | 1 | Capture byte request |
| capAck | input | 1 | Capture acknowledge |
| rdStrobe | input | 1 | Host read strobe |
| capDone | output | 1 | Capture frame finished pulse |
| busDataOut | output | 8 | Capture byte to the host |
| playSpace | input | 1 | Sink can accept a playback frame |
| playReq | output | 1 | Playback byte request |
| playAck | input | 1 | Playback acknowledge |
| wrStrobe | input | 1 | Host write strobe |
| busDataIn | input | 8 | Playback byte from the host |
| playFrame | output | 32 | Assembled playback frame |
| playDone | output | 1 | Playback frame finished pulse |

## Verification
A wrong byte index or latched format shows up at the very next acknowledged byte. Either busDataOut carries a byte from the wrong lane, or the done pulse comes one transfer early or late, so the bench compares every byte and every done cycle. A request that is not cleared after a transfer is visible one cycle later. A request that rises while the acknowledge is still held would count a byte twice, so the bench holds the acknowledge for random stretches. Format scrambles in the middle of a frame expose a format that is not frozen within two transfers.

// File: rtl/dmaSeqPkg.sv
package dmaSeqPkg;
  localparam int BYTE_W = 8;
  localparam int LANES = 4;
  localparam int FRAME_W = BYTE_W * LANES;
  localparam int IDX_W = $clog2(LANES);

  typedef enum logic [1:0] {
    FMT_MONO8    = 2'b00,
    FMT_MONO16   = 2'b01,
    FMT_STEREO8  = 2'b10,
    FMT_STEREO16 = 2'b11
  } fmtT;

  // strobes from a channel controller to the datapath
  typedef struct packed {
    logic load;
    logic xfer;
    logic first;
    logic [IDX_W-1:0] lane;
  } laneCtlT;

  function automatic logic [IDX_W:0] frameBytes(fmtT f);
    case (f)
      FMT_MONO8:    frameBytes = 3'd1;
      FMT_MONO16,
      FMT_STEREO8:  frameBytes = 3'd2;
      default:      frameBytes = 3'd4;
    endcase
  endfunction

  // lane of the frame word carried by byte number idx
  function automatic logic [IDX_W-1:0] laneFor(fmtT f, logic [IDX_W-1:0] idx);
    case (f)
      FMT_MONO8:    laneFor = '0;
      FMT_MONO16:   laneFor = idx;
      FMT_STEREO8:  laneFor = idx ^ 2'd1;
      default:      laneFor = idx ^ 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/dmaSeqCtrl.sv
module dmaSeqCtrl
  import dmaSeqPkg::*;
#(
  parameter bit IS_CAPTURE = 1'b1
) (
  input  logic    clk,
  input  logic    rstN,
  input  fmtT     fmtIn,
  input  logic    avail,
  input  logic    ack,
  input  logic    strobe,
  output logic    req,
  output logic    done,
  output logic    take,
  output laneCtlT ctl
);
  logic [IDX_W-1:0] idxQ;
  logic fullQ, reqQ, doneQ;
  fmtT fmtHeldQ;
  logic holding, xfer, lastByte, room;
  fmtT fmtEff;

  assign holding  = IS_CAPTURE ? fullQ : (idxQ != '0);
  assign fmtEff   = holding ? fmtHeldQ : fmtIn;
  assign xfer     = reqQ & ack & strobe;
  assign lastByte = ({1'b0, idxQ} == frameBytes(fmtEff) - 1'b1);
  assign take     = IS_CAPTURE && rstN && !fullQ && avail;
  assign room     = IS_CAPTURE ? fullQ : (holding || avail);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ     <= '0;
      fullQ    <= 1'b0;
      reqQ     <= 1'b0;
      doneQ    <= 1'b0;
      fmtHeldQ <= FMT_MONO8;
    end else begin
      doneQ <= 1'b0;
      if (take) begin
        fullQ    <= 1'b1;
        fmtHeldQ <= fmtIn;
      end
      if (xfer) begin
        reqQ <= 1'b0;
        if (!IS_CAPTURE && idxQ == '0) fmtHeldQ <= fmtIn;
        if (lastByte) begin
          idxQ  <= '0;
          doneQ <= 1'b1;
          if (IS_CAPTURE) fullQ <= 1'b0;
        end else begin
          idxQ <= idxQ + 1'b1;
        end
      end else if (!reqQ && !ack && room) begin
        reqQ <= 1'b1;
      end
    end
  end

  assign req       = reqQ;
  assign done      = doneQ;
  assign ctl.load  = take;
  assign ctl.xfer  = xfer;
  assign ctl.first = (idxQ == '0);
  assign ctl.lane  = laneFor(fmtEff, idxQ);

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rstN)
    xfer |=> !reqQ); // R4
  AST_REQ_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !reqQ) |=> !reqQ); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ); // R7
  AST_DONE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> idxQ == '0); // R7
  AST_FMT_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    holding |-> $stable(fmtEff)); // R8
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, idxQ} < frameBytes(fmtEff)); // R1
  AST_CAP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (IS_CAPTURE && reqQ) |-> fullQ); // R5
endmodule

// File: rtl/dmaSeqPath.sv
module dmaSeqPath
  import dmaSeqPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  laneCtlT            capCtl,
  input  laneCtlT            playCtl,
  input  logic [FRAME_W-1:0] capFrame,
  input  logic [BYTE_W-1:0]  busDataIn,
  output logic [BYTE_W-1:0]  busDataOut,
  output logic [FRAME_W-1:0] playFrame
);
  logic [FRAME_W-1:0] capQ, playQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capQ <= '0;
    end else if (capCtl.load) begin
      capQ <= capFrame;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      playQ <= '0;
    end else if (playCtl.xfer) begin
      for (int k = 0; k < LANES; k++) begin
        if (playCtl.lane == k[IDX_W-1:0])
          playQ[k*BYTE_W +: BYTE_W] <= busDataIn;
        else if (playCtl.first)
          playQ[k*BYTE_W +: BYTE_W] <= '0;
      end
    end
  end

  assign busDataOut = capQ[capCtl.lane*BYTE_W +: BYTE_W];
  assign playFrame  = playQ;

  AST_PLAY_LAND: assert property (@(posedge clk) disable iff (!rstN)
    playCtl.xfer |=> playQ[$past(playCtl.lane)*BYTE_W +: BYTE_W] == $past(busDataIn)); // R3
endmodule

// File: rtl/dmaByteSeq.sv
module dmaByteSeq
  import dmaSeqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  fmtSel,
  input  logic        capValid,
  input  logic [31:0] capFrame,
  output logic        capTake,
  output logic        capReq,
  input  logic        capAck,
  input  logic        rdStrobe,
  output logic        capDone,
  output logic [7:0]  busDataOut,
  input  logic        playSpace,
  output logic        playReq,
  input  logic        playAck,
  input  logic        wrStrobe,
  input  logic [7:0]  busDataIn,
  output logic [31:0] playFrame,
  output logic        playDone
);
  laneCtlT capCtl, playCtl;
  logic playTakeUnused;
  fmtT fmtIn;
  assign fmtIn = fmtT'(fmtSel);

  dmaSeqCtrl #(.IS_CAPTURE(1'b1)) capCtrl (
    .clk(clk), .rstN(rstN), .fmtIn(fmtIn), .avail(capValid),
    .ack(capAck), .strobe(rdStrobe), .req(capReq), .done(capDone),
    .take(capTake), .ctl(capCtl));

  dmaSeqCtrl #(.IS_CAPTURE(1'b0)) playCtrl (
    .clk(clk), .rstN(rstN), .fmtIn(fmtIn), .avail(playSpace),
    .ack(playAck), .strobe(wrStrobe), .req(playReq), .done(playDone),
    .take(playTakeUnused), .ctl(playCtl));

  dmaSeqPath path (
    .clk(clk), .rstN(rstN), .capCtl(capCtl), .playCtl(playCtl),
    .capFrame(capFrame), .busDataIn(busDataIn),
    .busDataOut(busDataOut), .playFrame(playFrame));
endmodule

// File: tb/dmaByteSeq_test.sv
`timescale 1ns/1ps
module dmaByteSeq_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] fmtSel = 2'b00;
  logic capValid = 1'b0, capAck = 1'b0, rdStrobe = 1'b0;
  logic [31:0] capFrame = '0;
  logic playSpace = 1'b0, playAck = 1'b0, wrStrobe = 1'b0;
  logic [7:0] busDataIn = '0;
  logic capTake, capReq, capDone, playReq, playDone;
  logic [7:0] busDataOut;
  logic [31:0] playFrame;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  dmaByteSeq uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int nBytes(logic [1:0] f);
    return (f == 2'b00) ? 1 : (f == 2'b11) ? 4 : 2;
  endfunction

  function automatic logic [7:0] expByte(logic [1:0] f, logic [31:0] fr, int i);
    case (f)
      2'b00: return fr[7:0];
      2'b01: return (i == 0) ? fr[7:0] : fr[15:8];
      2'b10: return (i == 0) ? fr[15:8] : fr[7:0];
      default: case (i)
        0: return fr[23:16];
        1: return fr[31:24];
        2: return fr[7:0];
        default: return fr[15:8];
      endcase
    endcase
  endfunction

  function automatic logic [31:0] expPlay(logic [1:0] f, logic [31:0] fr);
    case (f)
      2'b00: return {24'h0, fr[7:0]};
      2'b11: return fr;
      default: return {16'h0, fr[15:0]};
    endcase
  endfunction

  task automatic waitReq(input bit cap);
    int g = 0;
    while (((cap ? capReq : playReq) !== 1'b1) && g < 40) begin
      @(negedge clk); g++;
    end
    chk(cap ? "R4 cap request rises" : "R6 play request rises", cap ? capReq : playReq, 1);
  endtask

  task automatic capRun(input logic [1:0] fmt, input logic [31:0] fr, input bit mess);
    int n = nBytes(fmt);
    @(negedge clk);
    fmtSel = fmt; capFrame = fr; capValid = 1'b1;
    #1 chk("R5 take pulse", capTake, 1);
    @(negedge clk);
    capValid = 1'b0;
    chk("R5 take one cycle", capTake, 0);
    for (int i = 0; i < n; i++) begin
      if (mess) fmtSel = 2'($urandom);
      waitReq(1);
      if (mess && ($urandom % 2)) begin
        rdStrobe = 1'b1;
        @(negedge clk);
        chk("R10 strobe w/o ack keeps req", capReq, 1);
        chk("R10 same byte", busDataOut, expByte(fmt, fr, i));
        rdStrobe = 1'b0; capAck = 1'b1;
        @(negedge clk);
        chk("R10 ack w/o strobe keeps req", capReq, 1);
      end
      capAck = 1'b1; rdStrobe = 1'b1;
      #1 chk("R2 capture byte", busDataOut, expByte(fmt, fr, i));
      @(negedge clk);
      chk("R4 req low after xfer", capReq, 0);
      chk("R7 cap done timing", capDone, (i == n - 1) ? 1 : 0);
      if (mess) begin
        int hold = $urandom % 3;
        for (int h = 0; h < hold; h++) begin
          @(negedge clk);
          chk("R4 no rise while ack held", capReq, 0);
        end
      end
      capAck = 1'b0; rdStrobe = 1'b0;
      @(negedge clk);
      chk("R7 cap done one cycle", capDone, 0);
    end
  endtask

  task automatic playRun(input logic [1:0] fmt, input logic [31:0] fr, input bit mess);
    int n = nBytes(fmt);
    @(negedge clk);
    fmtSel = fmt; playSpace = 1'b1;
    for (int i = 0; i < n; i++) begin
      waitReq(0);
      if (mess && ($urandom % 2)) begin
        playAck = 1'b1;
        @(negedge clk);
        chk("R10 play ack w/o strobe keeps req", playReq, 1);
      end
      playAck = 1'b1; wrStrobe = 1'b1; busDataIn = expByte(fmt, fr, i);
      @(negedge clk);
      chk("R4 play req low after xfer", playReq, 0);
      chk("R7 play done timing", playDone, (i == n - 1) ? 1 : 0);
      if (i == n - 1) chk("R3 assembled frame", playFrame, expPlay(fmt, fr));
      playSpace = 1'b0;
      if (mess) fmtSel = 2'($urandom);
      playAck = 1'b0; wrStrobe = 1'b0;
      @(negedge clk);
      chk("R7 play done one cycle", playDone, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R9 capReq in reset", capReq, 0);
    chk("R9 playReq in reset", playReq, 0);
    chk("R9 done in reset", {capDone, playDone}, 0);
    chk("R9 capTake in reset", capTake, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 no capture frame, no req", capReq, 0);
    chk("R6 no space, no play req", playReq, 0);
    for (int f = 0; f < 4; f++) begin
      capRun(2'(f), 32'hA1B2C3D4 + f, 1'b0);   // R1 R2
      playRun(2'(f), 32'h11223344 ^ f, 1'b0);  // R1 R3
    end
    // R8: format changes mid-frame must not alter the current frame
    fmtSel = 2'b11;
    capRun(2'b11, 32'hDEADBEEF, 1'b1);
    playRun(2'b11, 32'hCAFEF00D, 1'b1);
    capRun(2'b00, 32'h0000005A, 1'b1);
    for (int r = 0; r < 60; r++) begin
      capRun(2'($urandom), $urandom, 1'b1);
      playRun(2'($urandom), $urandom, 1'b1);
    end
    repeat (3) @(negedge clk);
    chk("R6 idle after frames", playReq, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule